// File: doc/BRIEF.md
# Parity-Checked Pipeline Flush Controller

This block guards the stage registers of a short in-order pipeline with one even-parity bit per stored word and turns a detected upset into a pipeline flush. While a stage register is being loaded, the block supplies the check bit for the new word. The pipeline keeps that bit next to the word. The stored word, its bit, the stage's valid flag and, for the early stages, the instruction address are then fed back to the block, which evaluates them in a register stage of its own. The compare is therefore never in series with the datapath.

An upset in a stage that sits before the memory stage can be retried. The block pulses a flush for one cycle, supplies the restart address of the oldest faulting instruction and increments a saturating event counter. An upset in the memory stage or later cannot be retried, because the instruction may already have changed memory. In that case the block sets a fatal flag that stays set until reset and does not flush. Stage registers, the register file and memory are not part of this block.

Top module: `pp_flush_ctrl`

## Requirements
- R1: For every stage s, `par_o[s]` is the XOR of all bits of that stage's slice of `wr_data_i`, so the stored word plus its check bit holds an even number of ones.
- R2: A stage s whose valid bit is 1 and whose stored word plus check bit holds an odd number of ones in cycle t is acted on in cycle t+1. Outputs in cycle t are unaffected by that stage's inputs in cycle t.
- R3: A stage whose valid bit is 0 never causes a flush or a fatal report, whatever its parity.
- R4: A faulty stage with index below `MEM_STAGE` makes `flush_o` 1 for exactly one cycle.
- R5: During a flush, `flush_pc_o` equals the `q_pc_i` slice that the faulting stage held in cycle t. Stage s uses bits [s*PC_W +: PC_W]. When several stages below `MEM_STAGE` fail in the same cycle, the highest index (the oldest instruction) supplies the address.
- R6: A faulty stage with index `MEM_STAGE` or above sets `fatal_o` in cycle t+1, and `fatal_o` stays 1 until reset. A flush is suppressed in any cycle in which a fatal error is reported, even if an earlier stage also failed.
- R7: `err_cnt_o` increases by one after every flush cycle and otherwise holds. It stops at its all-ones value.
- R8: Stage words presented during a flush cycle are not checked, because those instructions are being squashed. They cause neither a flush nor a fatal report in the following cycle.
- R9: While `rst_ni` is 0, `flush_o` and `fatal_o` are 0 and `err_cnt_o` is 0.
- R10: `flush_pc_o` is 0 in every cycle in which `flush_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | NUM_STAGES*DATA_W | Words being loaded into the stage registers |
| par_o | output | NUM_STAGES | Check bit to be stored with each loaded word |
| q_data_i | input | NUM_STAGES*DATA_W | Words currently held in the stage registers |
| q_par_i | input | NUM_STAGES | Check bits held with those words |
| q_vld_i | input | NUM_STAGES | Stage holds a live instruction |
| q_pc_i | input | MEM_STAGE*PC_W | Instruction address of each stage before the memory stage |
| flush_o | output | 1 | One-cycle flush request |
| flush_pc_o | output | PC_W | Restart address during a flush, else 0 |
| fatal_o | output | 1 | Sticky unrecoverable error |
| err_cnt_o | output | CNT_W | Saturating count of recovered errors |

## Verification
The bench builds the block with five stages, the memory stage at index 3, 12-bit words, 16-bit addresses and a 4-bit counter. The narrow counter means saturation is reached after fifteen recoveries, inside a short run. Having two stages at or past the cutoff lets both the fatal path and the case of a simultaneous early and late error be exercised. Three recoverable stages are enough to test the oldest-first choice of restart address and the squashing of checks during a flush.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;
  typedef enum logic {CLS_RETRY, CLS_FATAL} stage_cls_e;

  function automatic stage_cls_e stage_class(input int s, input int mem_stage);
    return (s < mem_stage) ? CLS_RETRY : CLS_FATAL;
  endfunction
endpackage

// File: rtl/pfc_parity_enc.sv
`timescale 1ns/1ps
module pfc_parity_enc #(
  parameter int NUM_STAGES = 5,
  parameter int DATA_W     = 32
) (
  input  logic [NUM_STAGES*DATA_W-1:0] wr_data_i,
  output logic [NUM_STAGES-1:0]        par_o
);
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_enc
    assign par_o[s] = ^wr_data_i[s*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/pfc_check_stage.sv
`timescale 1ns/1ps
module pfc_check_stage #(
  parameter int NUM_STAGES = 5,
  parameter int DATA_W     = 32,
  parameter int PC_W       = 32,
  parameter int MEM_STAGE  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         squash_i,
  input  logic [NUM_STAGES*DATA_W-1:0] q_data_i,
  input  logic [NUM_STAGES-1:0]        q_par_i,
  input  logic [NUM_STAGES-1:0]        q_vld_i,
  input  logic [MEM_STAGE*PC_W-1:0]    q_pc_i,
  output logic [NUM_STAGES-1:0]        err_o,
  output logic [MEM_STAGE*PC_W-1:0]    pc_o
);
  logic [NUM_STAGES-1:0] syn;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_syn
    assign syn[s] = q_vld_i[s] & (^{q_data_i[s*DATA_W +: DATA_W], q_par_i[s]});
  end

  // squashed instructions are not checked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= '0;
      pc_o  <= '0;
    end else begin
      err_o <= squash_i ? '0 : syn;
      pc_o  <= q_pc_i;
    end
  end
endmodule

// File: rtl/pfc_flush_sel.sv
`timescale 1ns/1ps
module pfc_flush_sel
  import pfc_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int PC_W       = 32,
  parameter int MEM_STAGE  = 3
) (
  input  logic [NUM_STAGES-1:0]     err_i,
  input  logic [MEM_STAGE*PC_W-1:0] pc_i,
  output logic                      flush_o,
  output logic [PC_W-1:0]           flush_pc_o,
  output logic                      fatal_now_o
);
  logic            retry_any;
  logic [PC_W-1:0] pc_sel;

  always_comb begin
    retry_any   = 1'b0;
    fatal_now_o = 1'b0;
    pc_sel      = '0;
    // ascending scan: the last hit is the oldest instruction
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (err_i[s]) begin
        if (stage_class(s, MEM_STAGE) == CLS_RETRY) begin
          retry_any = 1'b1;
          pc_sel    = pc_i[s*PC_W +: PC_W];
        end else begin
          fatal_now_o = 1'b1;
        end
      end
    end
    flush_o    = retry_any & ~fatal_now_o;
    flush_pc_o = flush_o ? pc_sel : '0;
  end
endmodule

// File: rtl/pfc_err_track.sv
`timescale 1ns/1ps
module pfc_err_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             fatal_now_i,
  output logic             fatal_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fatal_q   <= 1'b0;
      err_cnt_o <= '0;
    end else begin
      fatal_q <= fatal_q | fatal_now_i;
      if (flush_i && err_cnt_o != CNT_MAX) err_cnt_o <= err_cnt_o + 1'b1;
    end
  end

  assign fatal_o = fatal_q | fatal_now_i;
endmodule

// File: rtl/pp_flush_ctrl.sv
`timescale 1ns/1ps
module pp_flush_ctrl #(
  parameter int NUM_STAGES = 5,
  parameter int DATA_W     = 32,
  parameter int PC_W       = 32,
  parameter int MEM_STAGE  = 3,
  parameter int CNT_W      = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_STAGES*DATA_W-1:0] wr_data_i,
  output logic [NUM_STAGES-1:0]        par_o,
  input  logic [NUM_STAGES*DATA_W-1:0] q_data_i,
  input  logic [NUM_STAGES-1:0]        q_par_i,
  input  logic [NUM_STAGES-1:0]        q_vld_i,
  input  logic [MEM_STAGE*PC_W-1:0]    q_pc_i,
  output logic                         flush_o,
  output logic [PC_W-1:0]              flush_pc_o,
  output logic                         fatal_o,
  output logic [CNT_W-1:0]             err_cnt_o
);
  logic [NUM_STAGES-1:0]     err_q;
  logic [MEM_STAGE*PC_W-1:0] pc_q;
  logic                      fatal_now;

  pfc_parity_enc #(.NUM_STAGES(NUM_STAGES), .DATA_W(DATA_W)) enc_i (
    .wr_data_i(wr_data_i),
    .par_o    (par_o)
  );

  pfc_check_stage #(
    .NUM_STAGES(NUM_STAGES), .DATA_W(DATA_W), .PC_W(PC_W), .MEM_STAGE(MEM_STAGE)
  ) chk_stage_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .squash_i(flush_o),
    .q_data_i(q_data_i),
    .q_par_i (q_par_i),
    .q_vld_i (q_vld_i),
    .q_pc_i  (q_pc_i),
    .err_o   (err_q),
    .pc_o    (pc_q)
  );

  pfc_flush_sel #(.NUM_STAGES(NUM_STAGES), .PC_W(PC_W), .MEM_STAGE(MEM_STAGE)) sel_i (
    .err_i      (err_q),
    .pc_i       (pc_q),
    .flush_o    (flush_o),
    .flush_pc_o (flush_pc_o),
    .fatal_now_o(fatal_now)
  );

  pfc_err_track #(.CNT_W(CNT_W)) track_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_o),
    .fatal_now_i(fatal_now),
    .fatal_o    (fatal_o),
    .err_cnt_o  (err_cnt_o)
  );
endmodule

// File: rtl/pp_flush_ctrl_chk.sv
`timescale 1ns/1ps
module pp_flush_ctrl_chk #(
  parameter int NUM_STAGES = 5,
  parameter int DATA_W     = 32,
  parameter int PC_W       = 32,
  parameter int MEM_STAGE  = 3,
  parameter int CNT_W      = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_STAGES*DATA_W-1:0] q_data_i,
  input logic [NUM_STAGES-1:0]        q_par_i,
  input logic [NUM_STAGES-1:0]        q_vld_i,
  input logic                         flush_o,
  input logic [PC_W-1:0]              flush_pc_o,
  input logic                         fatal_o,
  input logic [CNT_W-1:0]             err_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic early_odd, late_odd;

  always_comb begin
    early_odd = 1'b0;
    late_odd  = 1'b0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (q_vld_i[s] && (^{q_data_i[s*DATA_W +: DATA_W], q_par_i[s]})) begin
        if (s < MEM_STAGE) early_odd = 1'b1;
        else               late_odd  = 1'b1;
      end
    end
  end

  assert_flush_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(early_odd) && !$past(late_odd));

  assert_fatal_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fatal_o) |-> $past(late_odd));

  assert_fatal_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && err_cnt_o != CNT_MAX) |=> err_cnt_o == CNT_W'($past(err_cnt_o) + 1'b1));

  assert_cnt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o || err_cnt_o == CNT_MAX) |=> $stable(err_cnt_o));

  assert_pc_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_o |-> flush_pc_o == '0);
endmodule

bind pp_flush_ctrl pp_flush_ctrl_chk #(
  .NUM_STAGES(NUM_STAGES), .DATA_W(DATA_W), .PC_W(PC_W),
  .MEM_STAGE(MEM_STAGE), .CNT_W(CNT_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .q_data_i  (q_data_i),
  .q_par_i   (q_par_i),
  .q_vld_i   (q_vld_i),
  .flush_o   (flush_o),
  .flush_pc_o(flush_pc_o),
  .fatal_o   (fatal_o),
  .err_cnt_o (err_cnt_o)
);

// File: tb/pp_flush_ctrl_tb_top.sv
`timescale 1ns/1ps
module pp_flush_ctrl_tb_top;
  localparam int NS   = 5;
  localparam int DW   = 12;
  localparam int PCW  = 16;
  localparam int MEM  = 3;
  localparam int CW   = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NS*DW-1:0] wr_data_i = '0;
  logic [NS-1:0]    par_o;
  logic [NS*DW-1:0] q_data_i = '0;
  logic [NS-1:0]    q_par_i = '0;
  logic [NS-1:0]    q_vld_i = '0;
  logic [MEM*PCW-1:0] q_pc_i = '0;
  logic             flush_o;
  logic [PCW-1:0]   flush_pc_o;
  logic             fatal_o;
  logic [CW-1:0]    err_cnt_o;

  always #4 clk_i = ~clk_i;

  pp_flush_ctrl #(.NUM_STAGES(NS), .DATA_W(DW), .PC_W(PCW), .MEM_STAGE(MEM), .CNT_W(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_data_i(wr_data_i), .par_o(par_o),
    .q_data_i(q_data_i), .q_par_i(q_par_i), .q_vld_i(q_vld_i), .q_pc_i(q_pc_i),
    .flush_o(flush_o), .flush_pc_o(flush_pc_o), .fatal_o(fatal_o), .err_cnt_o(err_cnt_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // stimulus state
  logic [DW-1:0]  wd[NS];
  logic [DW-1:0]  qd[NS];
  bit             qbad[NS];
  bit             qv[NS];
  logic [PCW-1:0] qpc[MEM];

  // reference model
  bit m_flush = 0, m_sticky = 0, m_fnow = 0;
  int m_pc = 0, m_cnt = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic fresh(input bit all_valid);
    for (int s = 0; s < NS; s++) begin
      wd[s] = DW'($urandom); qd[s] = DW'($urandom); qbad[s] = 0;
      qv[s] = all_valid ? 1'b1 : 1'($urandom);
    end
    for (int s = 0; s < MEM; s++) qpc[s] = PCW'($urandom);
  endtask

  task automatic cyc(input string tag);
    bit n_flush, n_fnow, n_sticky, rec;
    int n_pc, n_cnt;
    for (int s = 0; s < NS; s++) begin
      wr_data_i[s*DW +: DW] = wd[s];
      q_data_i[s*DW +: DW]  = qd[s];
      q_par_i[s]            = (^qd[s]) ^ qbad[s];
      q_vld_i[s]            = qv[s];
    end
    for (int s = 0; s < MEM; s++) q_pc_i[s*PCW +: PCW] = qpc[s];
    #1;
    for (int s = 0; s < NS; s++) chk("R1", "par_o", int'(par_o[s]), int'(^wd[s]));
    chk("R2", {tag, " same-cycle flush_o"}, int'(flush_o), int'(m_flush));
    n_cnt    = m_flush ? ((m_cnt == MAXC) ? m_cnt : m_cnt + 1) : m_cnt;
    n_sticky = m_sticky | m_fnow;
    n_fnow = 0; rec = 0; n_pc = 0;
    if (!m_flush) begin
      for (int s = 0; s < NS; s++) begin
        if (qv[s] && qbad[s]) begin
          if (s >= MEM) n_fnow = 1;
          else begin rec = 1; n_pc = int'(qpc[s]); end
        end
      end
    end
    n_flush = rec && !n_fnow;
    if (!n_flush) n_pc = 0;
    @(posedge clk_i);
    m_flush = n_flush; m_pc = n_pc; m_fnow = n_fnow; m_sticky = n_sticky; m_cnt = n_cnt;
    @(negedge clk_i);
    chk("R4", {tag, " flush_o"},    int'(flush_o),    int'(m_flush));
    chk("R5", {tag, " flush_pc_o"}, int'(flush_pc_o), m_pc);
    chk("R6", {tag, " fatal_o"},    int'(fatal_o),    int'(m_sticky | m_fnow));
    chk("R7", {tag, " err_cnt_o"},  int'(err_cnt_o),  m_cnt);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin wd[s] = '0; qd[s] = '0; qbad[s] = 0; qv[s] = 0; end
    for (int s = 0; s < MEM; s++) qpc[s] = '0;
    // R9: reset state, with a bad valid word present
    q_vld_i = '1; q_par_i = 5'b00001;
    repeat (2) @(negedge clk_i);
    chk("R9", "flush_o", int'(flush_o), 0);
    chk("R9", "fatal_o", int'(fatal_o), 0);
    chk("R9", "err_cnt_o", int'(err_cnt_o), 0);
    rst_ni = 1'b1;

    // clean traffic, mixed valids
    for (int i = 0; i < 20; i++) begin fresh(0); cyc("clean"); end

    // R2/R4/R5: single recoverable error in each early stage, then flush cycle
    for (int s = 0; s < MEM; s++) begin
      fresh(1); qbad[s] = 1; cyc("single");
      fresh(1); cyc("flush");
      fresh(1); cyc("after");
    end

    // R3: bad parity in invalid stages is ignored
    fresh(1);
    for (int s = 0; s < NS; s++) begin qv[s] = 0; qbad[s] = 1; end
    cyc("invalid");
    fresh(1); cyc("invalid-after");

    // R5: several early errors, oldest address wins
    fresh(1); qbad[0] = 1; qbad[2] = 1; cyc("multi02");
    fresh(1); cyc("flush");
    fresh(1); qbad[0] = 1; qbad[1] = 1; cyc("multi01");
    fresh(1); cyc("flush");

    // R8: errors presented during the flush cycle are squashed
    fresh(1); qbad[1] = 1; cyc("pre-squash");
    fresh(1); qbad[0] = 1; qbad[4] = 1; cyc("squashed");
    fresh(1); cyc("post-squash");

    // R7: saturation of the counter
    for (int i = 0; i < MAXC + 3; i++) begin
      fresh(1); qbad[i % MEM] = 1; cyc("sat");
      fresh(1); cyc("sat-flush");
    end

    // R6: early + late error in the same cycle -> fatal, no flush
    fresh(1); qbad[1] = 1; qbad[MEM] = 1; cyc("fatal-mixed");
    fresh(1); cyc("fatal-hold");
    // R6: late-only error, sticky flag stays
    fresh(1); qbad[NS-1] = 1; cyc("fatal-late");
    for (int i = 0; i < 4; i++) begin fresh(0); cyc("fatal-sticky"); end
    // recoverable errors still flush after fatal
    fresh(1); qbad[2] = 1; cyc("post-fatal");
    fresh(1); cyc("post-fatal-flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule